// File: doc/BRIEF.md
# Issue Stall and Bubble Timer

This block sits next to the group former of an in-order, multi-issue core. It keeps track of issue restrictions that last several cycles after certain instructions issue. The group former reports, one pulse per event, which of six triggering events happened in the current cycle:

- an FP compare issued;
- a control transfer issued;
- a 64-bit multiply issued;
- a 64-bit divide issued;
- a condition-code register write issued;
- a state-register read reached the head of the instruction buffer.

The block answers with a per-class issue block vector and a single all-slots-blocked flag. The group former must not place an instruction of a blocked class into the group it is forming in that cycle.

Each triggering event owns an independent countdown window with its own length and its own set of covered classes. A trigger sampled at a clock edge loads its window to the full length at that edge. The window then stays active for exactly that many cycles. Windows that overlap run side by side. A class stays blocked while any window that covers it is still counting.

Top module: `ist_timer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every window, so that after that edge blk_class is 6'b000000 and blk_all is 0. Reset wins over any trigger sampled at the same edge.
- R2: A pulse on fcmp_iss sampled at edge t sets blk_class bits 0 (FP conditional move on register), 1 (FP double store), 2 (64-bit multiply) and 3 (64-bit divide) for the 2 cycles after edges t and t+1. It touches neither bits 4 and 5 nor blk_all.
- R3: A pulse on cti_iss sampled at edge t sets blk_class bits 4 (FP double load) and 5 (atomic-type load) for the 2 cycles after edges t and t+1. It touches neither bits 0 to 3 nor blk_all.
- R4: A pulse on div_iss sampled at edge t holds blk_all high for 68 cycles, from edge t up to edge t+68.
- R5: A pulse on mul_iss sampled at edge t holds blk_all high for 19 cycles.
- R6: A pulse on ccwr_iss sampled at edge t holds blk_all high for 4 cycles.
- R7: A pulse on srd_head sampled at edge t holds blk_all high for 5 cycles: the 4-cycle dispatch wait plus the read's own issue cycle.
- R8: Every window counts down on its own. A trigger that repeats while its window is still running reloads that window to its full length. Triggers on other windows neither shorten nor extend it.
- R9: While blk_all is high, all six blk_class bits are high.
- R10: When no window is running, blk_class is 6'b000000 and blk_all is 0. No output is raised without a preceding trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fcmp_iss | input | 1 | An FP compare issued this cycle |
| cti_iss | input | 1 | A control transfer issued this cycle |
| mul_iss | input | 1 | A 64-bit multiply issued this cycle |
| div_iss | input | 1 | A 64-bit divide issued this cycle |
| ccwr_iss | input | 1 | A condition-code register write issued this cycle |
| srd_head | input | 1 | A state-register read reached the buffer head this cycle |
| blk_class | output | 6 | Per-class issue block: bit 0 FP cond move, 1 FP double store, 2 multiply, 3 divide, 4 FP double load, 5 atomic load |
| blk_all | output | 1 | All issue slots blocked |

## Verification
On every cycle, the assertions check four things:
- each window reloads to its full length on a trigger;
- each window steps down by exactly one while it runs untriggered;
- no count exceeds its window length;
- every trigger raises its own block one cycle later, and blk_all implies that all class bits are set.

Only the bench scenarios can show the exact length of each window and the clean drop to zero at its end. The same holds for the independence of overlapping windows at chosen offsets and for reset cancelling a running window. The bench compares these against trigger times that it records itself.

// File: rtl/ist_pkg.sv
package ist_pkg;

  localparam int NWIN = 6;
  localparam int NCLS = 6;

  // window indices (also the bit order of the packed trigger vector)
  localparam int W_FCMP = 0;
  localparam int W_CTI  = 1;
  localparam int W_MUL  = 2;
  localparam int W_DIV  = 3;
  localparam int W_CCWR = 4;
  localparam int W_SRD  = 5;

  // class indices (bit positions of blk_class)
  localparam int C_FMOVR = 0;
  localparam int C_STDF  = 1;
  localparam int C_MULX  = 2;
  localparam int C_DIVX  = 3;
  localparam int C_LDDF  = 4;
  localparam int C_ATOM  = 5;

  // a window that stalls every issue slot
  function automatic logic win_is_global(input int w);
    return (w == W_MUL) || (w == W_DIV) || (w == W_CCWR) || (w == W_SRD);
  endfunction

  // does window w cover class c
  function automatic logic win_covers(input int w, input int c);
    if (win_is_global(w)) return 1'b1;
    if (w == W_FCMP)      return (c >= C_FMOVR) && (c <= C_DIVX);
    if (w == W_CTI)       return (c == C_LDDF) || (c == C_ATOM);
    return 1'b0;
  endfunction

endpackage

// File: rtl/ist_window.sv
module ist_window #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active
);

  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(LEN);

  logic [CW-1:0] cnt;

  // next count: full reload on trigger, otherwise step toward zero
  function automatic logic [CW-1:0] count_next(input logic [CW-1:0] cur,
                                               input logic t);
    if (t)              return FULL;
    else if (cur != '0) return cur - 1'b1;
    else                return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= count_next(cnt, trig);
  end

  assign active = (cnt != '0);

  assert_load_R8: assert property (@(posedge clk) disable iff (rst)
    trig |=> (cnt == FULL));

  assert_countdown_R8: assert property (@(posedge clk) disable iff (rst)
    (active && !trig) |=> (cnt == $past(cnt) - 1'b1));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

endmodule

// File: rtl/ist_mask.sv
module ist_mask
  import ist_pkg::*;
(
  input  logic [NWIN-1:0] win_act,
  output logic [NCLS-1:0] blk_class,
  output logic            blk_all
);

  logic [NWIN-1:0] glob_sel;

  for (genvar w = 0; w < NWIN; w++) begin : g_glob
    assign glob_sel[w] = win_act[w] & win_is_global(w);
  end

  assign blk_all = |glob_sel;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [NWIN-1:0] hit;
    for (genvar w = 0; w < NWIN; w++) begin : g_hit
      assign hit[w] = win_act[w] & win_covers(w, c);
    end
    assign blk_class[c] = |hit;
  end

endmodule

// File: rtl/ist_timer.sv
module ist_timer
  import ist_pkg::*;
#(
  parameter int FCMP_LEN = 2,
  parameter int CTI_LEN  = 2,
  parameter int MUL_LEN  = 19,
  parameter int DIV_LEN  = 68,
  parameter int CCWR_LEN = 4,
  parameter int SRD_LEN  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fcmp_iss,
  input  logic            cti_iss,
  input  logic            mul_iss,
  input  logic            div_iss,
  input  logic            ccwr_iss,
  input  logic            srd_head,
  output logic [NCLS-1:0] blk_class,
  output logic            blk_all
);

  logic [NWIN-1:0] trig_vec;
  logic [NWIN-1:0] win_act;

  assign trig_vec[W_FCMP] = fcmp_iss;
  assign trig_vec[W_CTI]  = cti_iss;
  assign trig_vec[W_MUL]  = mul_iss;
  assign trig_vec[W_DIV]  = div_iss;
  assign trig_vec[W_CCWR] = ccwr_iss;
  assign trig_vec[W_SRD]  = srd_head;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int L = (g == W_FCMP) ? FCMP_LEN :
                       (g == W_CTI)  ? CTI_LEN  :
                       (g == W_MUL)  ? MUL_LEN  :
                       (g == W_DIV)  ? DIV_LEN  :
                       (g == W_CCWR) ? CCWR_LEN : SRD_LEN;
    ist_window #(.LEN(L)) u_win (
      .clk    (clk),
      .rst    (rst),
      .trig   (trig_vec[g]),
      .active (win_act[g])
    );
  end

  ist_mask u_mask (
    .win_act   (win_act),
    .blk_class (blk_class),
    .blk_all   (blk_all)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (blk_class == '0 && !blk_all));

  assert_fcmp_block_R2: assert property (@(posedge clk) disable iff (rst)
    fcmp_iss |=> (blk_class[C_FMOVR] && blk_class[C_STDF] &&
                  blk_class[C_MULX] && blk_class[C_DIVX]));

  assert_cti_block_R3: assert property (@(posedge clk) disable iff (rst)
    cti_iss |=> (blk_class[C_LDDF] && blk_class[C_ATOM]));

  assert_div_block_R4: assert property (@(posedge clk) disable iff (rst)
    div_iss |=> blk_all);

  assert_mul_block_R5: assert property (@(posedge clk) disable iff (rst)
    mul_iss |=> blk_all);

  assert_ccwr_block_R6: assert property (@(posedge clk) disable iff (rst)
    ccwr_iss |=> blk_all);

  assert_srd_block_R7: assert property (@(posedge clk) disable iff (rst)
    srd_head |=> blk_all);

  assert_all_covers_R9: assert property (@(posedge clk) disable iff (rst)
    blk_all |-> (&blk_class));

endmodule

// File: tb/sim_ist_timer.sv
module sim_ist_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] trig = '0;
  logic [5:0] blk_class;
  logic       blk_all;

  int checks = 0;
  int fails  = 0;
  int pidx   = 0;
  int last  [NW];
  bit valid [NW];
  int lens  [NW] = '{2, 2, 19, 68, 4, 5};
  string wtag [NW] = '{"R2", "R3", "R5", "R4", "R6", "R7"};

  always #(CLK_PERIOD/2) clk = ~clk;

  ist_timer u0 (
    .clk       (clk),
    .rst       (rst),
    .fcmp_iss  (trig[0]),
    .cti_iss   (trig[1]),
    .mul_iss   (trig[2]),
    .div_iss   (trig[3]),
    .ccwr_iss  (trig[4]),
    .srd_head  (trig[5]),
    .blk_class (blk_class),
    .blk_all   (blk_all)
  );

  // coverage of classes by window, restated from the requirements
  function automatic bit covers(input int w, input int c);
    case (w)
      0:       return c < 4;
      1:       return c >= 4;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag);
    logic [5:0] exp_cls = '0;
    logic       exp_all = 1'b0;
    string      ctag;
    for (int w = 0; w < NW; w++) begin
      if (valid[w] && (pidx - last[w] < lens[w])) begin
        if (w >= 2) exp_all = 1'b1;
        for (int c = 0; c < 6; c++)
          if (covers(w, c)) exp_cls[c] = 1'b1;
      end
    end
    ctag = (exp_cls == '0) ? "R10" : (exp_all ? "R9" : tag);
    checks++;
    if (blk_class !== exp_cls) begin
      fails++;
      $display("FAIL %s blk_class at edge %0d: got %b expected %b",
               ctag, pidx, blk_class, exp_cls);
    end
    checks++;
    if (blk_all !== exp_all) begin
      fails++;
      $display("FAIL %s blk_all at edge %0d: got %b expected %b",
               tag, pidx, blk_all, exp_all);
    end
  endtask

  task automatic step(input logic [5:0] t, input logic r, input string tag);
    trig = t;
    rst  = r;
    @(posedge clk);
    pidx++;
    for (int w = 0; w < NW; w++) begin
      if (r) valid[w] = 1'b0;
      else if (t[w]) begin
        last[w]  = pidx;
        valid[w] = 1'b1;
      end
    end
    @(negedge clk);
    trig = '0;
    rst  = 1'b0;
    check(r ? "R1" : tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int w = 0; w < NW; w++) begin
      valid[w] = 1'b0;
      last[w]  = 0;
    end
    @(negedge clk);
    // reset, including reset with every trigger asserted
    step('0, 1'b1, "R1");
    step(6'b111111, 1'b1, "R1");
    idle(3, "R10");

    // single trigger per window, observed across and past its full length
    for (int w = 0; w < NW; w++) begin
      step(6'(1 << w), 1'b0, wtag[w]);
      idle(lens[w] + 3, wtag[w]);
    end

    // pairs of windows at chosen offsets, including retrigger of one window
    for (int a = 0; a < NW; a++)
      for (int b = 0; b < NW; b++)
        for (int off = 0; off < 4; off++) begin
          step(6'(1 << a), 1'b0, "R8");
          idle(off, "R8");
          step(6'(1 << b), 1'b0, "R8");
          idle(70, "R8");
        end

    // reset cancels a running divide window
    step(6'b001000, 1'b0, "R4");
    idle(10, "R4");
    step('0, 1'b1, "R1");
    idle(3, "R10");

    // pseudo-random sparse triggers with occasional reset
    for (int i = 0; i < 5000; i++) begin
      logic [5:0] t = '0;
      logic       r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[4:0] < 5'd6)  t[lfsr[2:0]] = 1'b1;
      if (lfsr[12:8] < 5'd6) t[lfsr[10:8]] = 1'b1;
      r = (lfsr[15:7] == 9'h1A5);
      step(t, r, "R8");
    end
    idle(75, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule